// File: doc/BRIEF.md
# SPI Slave Register-Access Engine

This block lets an external SPI master read and write a 16-bit, byte-addressed register space through a simple synchronous register-bus master port. The SPI pins run in mode 0: MSB first, MOSI sampled on the rising SCK edge, and MISO changed after the falling edge. The pins are brought into the system clock domain through two-flop synchronisers, so SCK must run well below the system clock. A transfer opens with a header of two or three bytes. This header carries the address and a 3-bit command. While the header shifts in, MISO streams the 24-bit interrupt request vector one byte at a time.

For a read, the engine fetches the first location as soon as the header is complete. The master then sends one wait byte, and data follows from the next byte on. Each later location is fetched during the byte in front of it, so no further wait bytes are needed. When the master sends 0xFF on MOSI during a data byte, that byte is the last one and nothing more is fetched. For a write, each complete data byte becomes one write strobe. Raising SEL ends any transfer and returns the engine to the header.

The engine is a single state machine. Its states are HDR0 (first header byte), HDR1 (second header byte), HDR2 (third header byte), RD_WAIT (wait byte), RD_DATA (read data), WR_DATA (write data) and DISCARD (the rest of the transfer is ignored). It moves through these transitions:
- HDR0→HDR1 after any byte.
- HDR1→HDR2 on the extended command.
- HDR1 or HDR2→RD_WAIT on read, →WR_DATA on write, and →DISCARD on any other command (or, from HDR2, on non-zero reserved bits).
- RD_WAIT→RD_DATA after the wait byte.
- RD_DATA→DISCARD on the terminating byte.
- Every state→HDR0 whenever SEL is high.

Top module: `spi_reg_engine`

## Requirements
- R1: In a two-byte header, byte 0 gives address bits 12:5. Byte 1 gives address bits 4:0 in its bits 7:3 and the command in bits 2:0. Address bits 15:13 are zero. Command 011b is read and 100b is write.
- R2: A byte-1 command of 110b selects a three-byte header. In byte 2, bits 7:5 are address bits 15:13, bits 4:2 are the command, and bits 1:0 are reserved. If the reserved bits are not 00b, the whole access is ignored and no strobe is issued.
- R3: During header byte 0, MISO carries irq_req[7:0], MSB first. During byte 1 it carries irq_req[15:8]. In a three-byte header, byte 2 carries irq_req[23:16].
- R4: A read issues bus_rd for the header address before the wait byte ends, and MISO is 0x00 during the wait byte. The byte after the wait byte returns the data of the header address. bus_rdata is taken the cycle after bus_rd.
- R5: After each read data byte whose MOSI value is not 0xFF, exactly one bus_rd is issued for the next address (+1). That data is returned in the following byte.
- R6: A read data byte with 0xFF on MOSI is the last one. No further bus_rd follows, and any later bytes in the transfer return 0x00.
- R7: In a write, each complete data byte gives one bus_wr, carrying that byte on bus_wdata. The address starts at the header address and rises by one per byte.
- R8: SEL going high at any point returns the engine to HDR0. A partly received byte produces no strobe, and the next transfer decodes a fresh header.
- R9: Command 000b and every undefined command produce no bus strobe, and MISO is 0x00 for the bytes after the header.
- R10: After reset, MISO is low and neither bus strobe is active.
- R11: bus_rd and bus_wr are never high together, and each is high for exactly one clock cycle per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI clock, mode 0 |
| spi_sel_n | input | 1 | SPI select, active low |
| spi_mosi | input | 1 | Master-to-slave data |
| spi_miso | output | 1 | Slave-to-master data (low while deselected) |
| bus_addr | output | 16 | Register-bus address |
| bus_wdata | output | 8 | Register-bus write data |
| bus_wr | output | 1 | Register-bus write strobe, one cycle |
| bus_rd | output | 1 | Register-bus read strobe, one cycle |
| bus_rdata | input | 8 | Register-bus read data, valid the cycle after bus_rd |
| irq_req | input | 24 | Interrupt request vector shown during the header |

## Verification
The hardest case to reach is the boundary between the terminating read byte and what comes after it. A prefetch that slips one location too far is visible only as one extra bus_rd. It is also visible as a non-zero byte in a transfer the master has already ended. The bench therefore clocks one more byte after the 0xFF marker, expects 0x00 on MISO for it, and checks that its queue of expected strobes is empty when SEL rises. The partial-byte case is reached by stopping SCK after four bits of a write data byte and raising SEL. The next transfer must then decode a fresh header at a new address.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

    typedef enum logic [2:0] {
        ST_HDR0,
        ST_HDR1,
        ST_HDR2,
        ST_RD_WAIT,
        ST_RD_DATA,
        ST_WR_DATA,
        ST_DISCARD
    } eng_state_t;

    localparam int CMD_W = 3;
    localparam logic [CMD_W-1:0] CMD_NOP   = 3'b000;
    localparam logic [CMD_W-1:0] CMD_READ  = 3'b011;
    localparam logic [CMD_W-1:0] CMD_WRITE = 3'b100;
    localparam logic [CMD_W-1:0] CMD_EXT   = 3'b110;

    // State entered once the command of the final header byte is known.
    function automatic eng_state_t cmd_target(input logic [CMD_W-1:0] cmd);
        unique case (cmd)
            CMD_READ:  return ST_RD_WAIT;
            CMD_WRITE: return ST_WR_DATA;
            default:   return ST_DISCARD;
        endcase
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
                else        chain <= {chain[STAGES-2:0], d_in[i]};
            end
            assign d_out[i] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/spi_byte_shift.sv
module spi_byte_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              sck,
    input  logic              mosi,
    input  logic [BYTE_W-1:0] load_byte,
    input  logic [BYTE_W-1:0] idle_byte,
    output logic              rx_done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              miso
);

    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic              sck_q;
    logic              rise, fall;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic              at_bound;

    assign rise = active &&  sck && !sck_q;
    assign fall = active && !sck &&  sck_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q    <= 1'b0;
            bit_cnt  <= '0;
            rx_sh    <= '0;
            rx_byte  <= '0;
            rx_done  <= 1'b0;
            tx_sh    <= '0;
            at_bound <= 1'b0;
        end else begin
            sck_q   <= sck;
            rx_done <= 1'b0;
            if (!active) begin
                bit_cnt  <= '0;
                at_bound <= 1'b0;
                tx_sh    <= idle_byte;
            end else begin
                if (rise) begin
                    rx_sh <= {rx_sh[BYTE_W-2:0], mosi};
                    if (bit_cnt == LAST_BIT) begin
                        bit_cnt  <= '0;
                        rx_done  <= 1'b1;
                        rx_byte  <= {rx_sh[BYTE_W-2:0], mosi};
                        at_bound <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                if (fall) begin
                    if (at_bound) begin
                        tx_sh    <= load_byte;
                        at_bound <= 1'b0;
                    end else begin
                        tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    assign miso = active && tx_sh[BYTE_W-1];

endmodule

// File: rtl/spi_reg_fsm.sv
module spi_reg_fsm
    import spi_reg_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8,
    parameter int IRQ_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              rx_done,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [IRQ_W-1:0]  irq,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] tx_next,
    output logic [BYTE_W-1:0] idle_byte,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              wr_stb,
    output logic              rd_stb
);

    localparam int LO_W  = 5;
    localparam int EXT_W = ADDR_W - LO_W - BYTE_W;
    localparam int RSV_W = BYTE_W - EXT_W - CMD_W;
    localparam logic [BYTE_W-1:0] TERM = {BYTE_W{1'b1}};

    eng_state_t        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0] rd_buf;
    logic              rd_cap;
    logic [CMD_W-1:0]  cmd0, cmd1;
    logic [RSV_W-1:0]  resv;

    assign cmd0 = rx_byte[CMD_W-1:0];
    assign cmd1 = rx_byte[BYTE_W-EXT_W-1 -: CMD_W];
    assign resv = rx_byte[RSV_W-1:0];

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!active) begin
            state_d = ST_HDR0;
        end else if (rx_done) begin
            unique case (state_q)
                ST_HDR0:    state_d = ST_HDR1;
                ST_HDR1:    state_d = (cmd0 == CMD_EXT) ? ST_HDR2 : cmd_target(cmd0);
                ST_HDR2:    state_d = (resv != '0) ? ST_DISCARD : cmd_target(cmd1);
                ST_RD_WAIT: state_d = ST_RD_DATA;
                ST_RD_DATA: state_d = (rx_byte == TERM) ? ST_DISCARD : ST_RD_DATA;
                ST_WR_DATA: state_d = ST_WR_DATA;
                ST_DISCARD: state_d = ST_DISCARD;
                default:    state_d = ST_HDR0;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HDR0;
        else        state_q <= state_d;
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            bus_addr <= '0;
            wr_data  <= '0;
            wr_stb   <= 1'b0;
            rd_stb   <= 1'b0;
            rd_cap   <= 1'b0;
            rd_buf   <= '0;
        end else begin
            wr_stb <= 1'b0;
            rd_stb <= 1'b0;
            rd_cap <= rd_stb;
            if (rd_cap) rd_buf <= rd_data;
            if (active && rx_done) begin
                case (state_q)
                    ST_HDR0: addr_q <= ADDR_W'({rx_byte, {LO_W{1'b0}}});
                    ST_HDR1: begin
                        addr_q[LO_W-1:0] <= rx_byte[BYTE_W-1 -: LO_W];
                        if (cmd0 == CMD_READ) begin
                            rd_stb   <= 1'b1;
                            bus_addr <= {addr_q[ADDR_W-1:LO_W], rx_byte[BYTE_W-1 -: LO_W]};
                        end
                    end
                    ST_HDR2: begin
                        addr_q[ADDR_W-1 -: EXT_W] <= rx_byte[BYTE_W-1 -: EXT_W];
                        if (cmd1 == CMD_READ && resv == '0) begin
                            rd_stb   <= 1'b1;
                            bus_addr <= {rx_byte[BYTE_W-1 -: EXT_W], addr_q[ADDR_W-EXT_W-1:0]};
                        end
                    end
                    ST_RD_DATA: begin
                        if (rx_byte != TERM) begin
                            addr_q   <= addr_q + 1'b1;
                            bus_addr <= addr_q + 1'b1;
                            rd_stb   <= 1'b1;
                        end
                    end
                    ST_WR_DATA: begin
                        wr_stb   <= 1'b1;
                        bus_addr <= addr_q;
                        wr_data  <= rx_byte;
                        addr_q   <= addr_q + 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Byte loaded into the transmit shifter at the next byte boundary
    always_comb begin
        unique case (state_q)
            ST_HDR1:    tx_next = irq[BYTE_W +: BYTE_W];
            ST_HDR2:    tx_next = irq[2*BYTE_W +: BYTE_W];
            ST_RD_DATA: tx_next = rd_buf;
            default:    tx_next = '0;
        endcase
    end

    assign idle_byte = irq[BYTE_W-1:0];

endmodule

// File: rtl/spi_reg_engine.sv
module spi_reg_engine #(
    parameter int ADDR_W      = 16,
    parameter int BYTE_W      = 8,
    parameter int IRQ_W       = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_sel_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [BYTE_W-1:0] bus_wdata,
    output logic              bus_wr,
    output logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_rdata,
    input  logic [IRQ_W-1:0]  irq_req
);

    localparam int PIN_N = 3;

    logic [PIN_N-1:0]  pins_s;
    logic              sck_s, sel_s, mosi_s, active;
    logic              rx_done;
    logic [BYTE_W-1:0] rx_byte, tx_next, idle_byte;

    spi_pin_sync #(
        .WIDTH   (PIN_N),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({spi_mosi, spi_sel_n, spi_sck}),
        .d_out (pins_s)
    );

    assign sck_s  = pins_s[0];
    assign sel_s  = pins_s[1];
    assign mosi_s = pins_s[2];
    assign active = !sel_s;

    spi_byte_shift #(.BYTE_W(BYTE_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .sck       (sck_s),
        .mosi      (mosi_s),
        .load_byte (tx_next),
        .idle_byte (idle_byte),
        .rx_done   (rx_done),
        .rx_byte   (rx_byte),
        .miso      (spi_miso)
    );

    spi_reg_fsm #(
        .ADDR_W (ADDR_W),
        .BYTE_W (BYTE_W),
        .IRQ_W  (IRQ_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .rx_done   (rx_done),
        .rx_byte   (rx_byte),
        .irq       (irq_req),
        .rd_data   (bus_rdata),
        .tx_next   (tx_next),
        .idle_byte (idle_byte),
        .bus_addr  (bus_addr),
        .wr_data   (bus_wdata),
        .wr_stb    (bus_wr),
        .rd_stb    (bus_rd)
    );

endmodule

// File: rtl/spi_reg_engine_chk.sv
module spi_reg_engine_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spi_sel_n,
    input logic              spi_miso,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr
);

    logic [2:0]        desel_cnt;
    logic              seen_rd, seen_wr;
    logic [ADDR_W-1:0] last_rd, last_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            desel_cnt <= '0;
            seen_rd   <= 1'b0;
            seen_wr   <= 1'b0;
            last_rd   <= '0;
            last_wr   <= '0;
        end else begin
            if (!spi_sel_n)          desel_cnt <= '0;
            else if (desel_cnt != 3'd7) desel_cnt <= desel_cnt + 1'b1;
            if (spi_sel_n) begin
                seen_rd <= 1'b0;
                seen_wr <= 1'b0;
            end else begin
                if (bus_rd) begin seen_rd <= 1'b1; last_rd <= bus_addr; end
                if (bus_wr) begin seen_wr <= 1'b1; last_wr <= bus_addr; end
            end
        end
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr)); // R11
    AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> !bus_rd); // R11
    AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> !bus_wr); // R11
    AST_RD_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && seen_rd) |-> (bus_addr == last_rd + 1'b1)); // R5
    AST_WR_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && seen_wr) |-> (bus_addr == last_wr + 1'b1)); // R7
    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (desel_cnt >= 3'd4) |-> (!bus_rd && !bus_wr && !spi_miso)); // R8

endmodule

bind spi_reg_engine spi_reg_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_sel_n (spi_sel_n),
    .spi_miso  (spi_miso),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr)
);

// File: tb/tb_spi_reg_engine.sv
module tb_spi_reg_engine;

    localparam int HALF = 10;

    logic        clk = 1'b0;
    logic        rst_n, sck, sel_n, mosi;
    logic        miso;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata, bus_rdata;
    logic        bus_wr, bus_rd;
    logic [23:0] irq;

    int total = 0;
    int bad = 0;
    int strobes = 0;

    typedef struct {
        bit          is_wr;
        logic [15:0] addr;
        logic [7:0]  data;
        string       req;
    } bus_item_t;
    bus_item_t exp_q[$];

    always #2 clk = ~clk;

    spi_reg_engine dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_sck   (sck),
        .spi_sel_n (sel_n),
        .spi_mosi  (mosi),
        .spi_miso  (miso),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .irq_req   (irq)
    );

    function automatic logic [7:0] mem_val(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
    endfunction

    // Register space model: data one cycle after the read strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= 8'h00;
        else if (bus_rd) bus_rdata <= mem_val(bus_addr);
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every bus strobe
    always @(negedge clk) begin
        if (rst_n && (bus_rd || bus_wr)) begin
            bus_item_t it;
            strobes++;
            check(!(bus_rd && bus_wr), "R11", "rd and wr together", {bus_rd, bus_wr}, 0);
            if (exp_q.size() == 0) begin
                check(1'b0, "R9", "unexpected strobe at addr", bus_addr, 0);
            end else begin
                it = exp_q.pop_front();
                check(bus_wr == it.is_wr, it.req, "strobe kind wr", bus_wr, it.is_wr);
                check(bus_addr == it.addr, it.req, "bus address", bus_addr, it.addr);
                if (it.is_wr)
                    check(bus_wdata == it.data, it.req, "write data", bus_wdata, it.data);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic push(input bit w, input logic [15:0] a, input logic [7:0] d, input string req);
        bus_item_t it;
        it.is_wr = w; it.addr = a; it.data = d; it.req = req;
        exp_q.push_back(it);
    endtask

    task automatic xfer(input logic [7:0] mo, input bit chk, input logic [7:0] exp, input string req);
        logic [7:0] mi;
        for (int i = 7; i >= 0; i--) begin
            mosi = mo[i];
            tick(HALF);
            mi[i] = miso;
            sck = 1'b1;
            tick(HALF);
            sck = 1'b0;
        end
        if (chk) check(mi == exp, req, "miso byte", mi, exp);
    endtask

    task automatic sel_on();
        sel_n = 1'b0;
        tick(2 * HALF);
    endtask

    task automatic sel_off();
        tick(HALF);
        sel_n = 1'b1;
        tick(4 * HALF);
    endtask

    task automatic header(input bit three, input logic [15:0] a, input logic [2:0] cmd,
                          input logic [1:0] resv);
        xfer(a[12:5], 1'b1, irq[7:0], "R3");
        xfer({a[4:0], three ? 3'b110 : cmd}, 1'b1, irq[15:8], "R3");
        if (three) xfer({a[15:13], cmd, resv}, 1'b1, irq[23:16], "R3");
    endtask

    task automatic wr_txn(input bit three, input logic [15:0] a, input int n,
                          input logic [7:0] seed, input string req0);
        sel_on();
        header(three, a, 3'b100, 2'b00);
        for (int k = 0; k < n; k++) begin
            logic [7:0] d;
            d = seed + 8'(k * 37);
            push(1'b1, a + 16'(k), d, (k == 0) ? req0 : "R7");
            xfer(d, 1'b0, 8'h00, "");
        end
        sel_off();
        check(exp_q.size() == 0, "R7", "writes still pending", exp_q.size(), 0);
    endtask

    task automatic rd_txn(input bit three, input logic [15:0] a, input int n, input string req0);
        push(1'b0, a, 8'h00, req0);
        sel_on();
        header(three, a, 3'b011, 2'b00);
        xfer(8'hFF, 1'b1, 8'h00, "R4");
        for (int k = 0; k < n; k++) begin
            if (k < n - 1) push(1'b0, a + 16'(k + 1), 8'h00, "R5");
            xfer((k == n - 1) ? 8'hFF : 8'h00, 1'b1, mem_val(a + 16'(k)), (k == 0) ? "R4" : "R5");
        end
        xfer(8'h00, 1'b1, 8'h00, "R6");
        sel_off();
        check(exp_q.size() == 0, "R6", "reads pending or missing", exp_q.size(), 0);
    endtask

    task automatic quiet_txn(input bit three, input logic [15:0] a, input logic [2:0] cmd,
                             input logic [1:0] resv, input string req);
        int s0;
        s0 = strobes;
        sel_on();
        header(three, a, cmd, resv);
        xfer(8'h3C, 1'b1, 8'h00, req);
        xfer(8'hC3, 1'b1, 8'h00, req);
        sel_off();
        check(strobes == s0, req, "strobes on ignored access", strobes - s0, 0);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        check(1'b0, "WATCHDOG", "run did not finish", 0, 1);
        finish_run();
    end

    initial begin
        rst_n = 1'b0; sck = 1'b0; sel_n = 1'b1; mosi = 1'b0; irq = 24'h3C_96_A5;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        check(miso == 1'b0, "R10", "miso after reset", miso, 0);
        check(bus_rd == 1'b0 && bus_wr == 1'b0, "R10", "strobes after reset", {bus_rd, bus_wr}, 0);

        // Two-byte header writes (R1, R7)
        wr_txn(1'b0, 16'h0ABC, 3, 8'h11, "R1");
        irq = 24'h81_7E_42;
        wr_txn(1'b0, 16'h1FFF, 2, 8'hF0, "R1");

        // Three-byte header write (R2)
        irq = 24'hD2_2D_E1;
        wr_txn(1'b1, 16'hE005, 2, 8'h44, "R2");

        // Reads with wait byte, prefetch and termination (R4, R5, R6)
        irq = 24'h5A_A5_0F;
        rd_txn(1'b0, 16'h0123, 3, "R4");
        rd_txn(1'b1, 16'hBFFE, 3, "R2");
        rd_txn(1'b0, 16'h0800, 1, "R4");

        // Ignored commands: no-op, undefined, bad reserved bits (R9, R2)
        irq = 24'h13_57_9B;
        quiet_txn(1'b0, 16'h0040, 3'b000, 2'b00, "R9");
        quiet_txn(1'b0, 16'h0041, 3'b101, 2'b00, "R9");
        quiet_txn(1'b1, 16'h6042, 3'b100, 2'b01, "R2");

        // Partial byte discarded at deselect, then a fresh header (R8)
        begin
            int s0;
            push(1'b1, 16'h0040, 8'h77, "R8");
            sel_on();
            header(1'b0, 16'h0040, 3'b100, 2'b00);
            xfer(8'h77, 1'b0, 8'h00, "");
            s0 = strobes;
            for (int i = 0; i < 4; i++) begin
                mosi = 1'b1; tick(HALF); sck = 1'b1; tick(HALF); sck = 1'b0;
            end
            sel_off();
            check(strobes == s0, "R8", "strobe from partial byte", strobes - s0, 0);
            check(miso == 1'b0, "R8", "miso while deselected", miso, 0);
        end
        wr_txn(1'b0, 16'h0100, 1, 8'h9D, "R8");

        check(exp_q.size() == 0, "R6", "scoreboard empty at end", exp_q.size(), 0);
        finish_run();
    end

endmodule